// File: doc/BRIEF.md
# Current-Mode Pulse-Frequency Boost Switch Controller

This block decides, clock by clock, whether the power switch of a boost converter conducts. It never runs at a fixed period. It starts a conduction interval whenever nothing holds it off. The interval ends in one of three ways: the inductor current reaches its limit, a maximum on-time runs out, or a hold-off condition appears. A current-limit or max-on ending is always followed by a fixed forced off-time. The inputs are digital flags from external comparators: current over its limit, output over its regulation threshold, and a combined shutdown request (over-temperature or a supply undervoltage). The output is one switch-enable line.

Every flag passes through a two-stage synchronizer before use. For a short window after each turn-on the current flag is disregarded, so that the reverse-recovery spike of the rectifier diode cannot end the interval early. All durations are counts of clock cycles set by parameters. The defaults are a 4-cycle blanking window, a 50-cycle forced off-time (5 µs at 10 MHz) and a 200-cycle on-time limit. The on-time limit must be larger than the blanking window.

Top module: `pfm_boost_ctrl`

## Requirements
- R1: While `rst_n` is low, `sw_en_o` is 0 and all timers are cleared. After reset is released, the first conduction interval may last the full on-time limit.
- R2: Every input flag is seen through two synchronizer flops. A change driven between two rising edges affects `sw_en_o` after the third rising edge that follows.
- R3: When the switch is idle and neither over-voltage nor shutdown is active, `sw_en_o` goes to 1 on the next rising edge. This includes the first edge after reset release.
- R4: During the first BLANK_CYC cycles of a conduction interval, the current flag has no effect. The cycle of turn-on counts as the first of these cycles.
- R5: A current flag seen after the blanking window turns the switch off. The switch then stays off for exactly OFF_CYC cycles.
- R6: If no current trip occurs, `sw_en_o` stays 1 for exactly MAX_ON_CYC cycles. The switch is then forced off for OFF_CYC cycles.
- R7: When the forced off-time ends, the switch turns on in the next cycle only if neither over-voltage nor shutdown is active. Otherwise it stays off until both are clear.
- R8: While over-voltage is seen, the switch is off. This holds in the blanking window as well.
- R9: While shutdown is seen, the switch is off. Shutdown takes priority over every other condition, including blanking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_trip_i | input | 1 | Inductor current over its limit (asynchronous flag) |
| ov_i | input | 1 | Boost output above its regulation threshold (asynchronous flag) |
| shdn_i | input | 1 | Shutdown request (asynchronous flag) |
| sw_en_o | output | 1 | Power switch enable, 1 = conducting |

## Verification
The bound checker watches several rules on every cycle. A synchronized shutdown or over-voltage flag always leaves the switch off in the following cycle. A current trip or on-time expiry ends conduction. A current flag inside the blanking window never ends it. Every turn-on happens with both hold-off flags clear, and no high pulse runs longer than the on-time limit. Exact cycle counts can only be shown by the directed scenarios. These are the three-edge input latency, the exact forced off-time, the trip instant at the edge of the blanking window, the continued hold-off after the off-time ends under over-voltage, and the cleared timers after a mid-pulse reset.

// File: rtl/pfm_boost_pkg.sv
package pfm_boost_pkg;

  // bit 0 of the state code is the switch drive
  typedef enum logic [1:0] {
    PS_IDLE  = 2'b00,
    PS_BLANK = 2'b01,
    PS_FOFF  = 2'b10,
    PS_ON    = 2'b11
  } pfm_state_e;

  localparam int unsigned FLAG_CS = 0;
  localparam int unsigned FLAG_OV = 1;
  localparam int unsigned FLAG_SD = 2;
  localparam int unsigned FLAG_W  = 3;

  // true in the final cycle of a window of len cycles counted from zero
  function automatic logic at_last(input int unsigned cnt, input int unsigned len);
    return cnt == len - 1;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b);
    return $clog2(max2(a, b) + 1);
  endfunction

endpackage

// File: rtl/pfm_sync.sv
module pfm_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= async_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= '0;
      else        stg[g] <= stg[g-1];
    end
  end

  assign sync_o = stg[STAGES-1];

endmodule

// File: rtl/pfm_seq.sv
module pfm_seq
  import pfm_boost_pkg::*;
#(
  parameter int unsigned BLANK_CYC  = 4,
  parameter int unsigned OFF_CYC    = 50,
  parameter int unsigned MAX_ON_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic ov_i,
  input  logic sd_i,
  output logic sw_o,
  output logic blank_o,
  output logic trip_o,
  output logic maxon_o
);

  localparam int unsigned CNT_W = cnt_width(OFF_CYC, MAX_ON_CYC);

  pfm_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hold;

  assign hold = ov_i | sd_i;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q + 1'b1;
    trip_o  = 1'b0;
    maxon_o = 1'b0;
    unique case (st_q)
      PS_IDLE: begin
        cnt_d = '0;
        if (!hold) st_d = PS_BLANK;
      end
      PS_BLANK: begin
        if (hold) begin
          st_d  = PS_IDLE;
          cnt_d = '0;
        end else if (at_last(32'(cnt_q), BLANK_CYC)) begin
          st_d = PS_ON;
        end
      end
      PS_ON: begin
        if (sd_i) begin
          st_d  = PS_IDLE;
          cnt_d = '0;
        end else if (cs_i) begin
          trip_o = 1'b1;
          st_d   = PS_FOFF;
          cnt_d  = '0;
        end else if (at_last(32'(cnt_q), MAX_ON_CYC)) begin
          maxon_o = 1'b1;
          st_d    = PS_FOFF;
          cnt_d   = '0;
        end else if (ov_i) begin
          st_d  = PS_IDLE;
          cnt_d = '0;
        end
      end
      PS_FOFF: begin
        if (at_last(32'(cnt_q), OFF_CYC)) begin
          cnt_d = '0;
          st_d  = hold ? PS_IDLE : PS_BLANK;
        end
      end
      default: begin
        st_d  = PS_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign sw_o    = st_q[0];
  assign blank_o = (st_q == PS_BLANK);

endmodule

// File: rtl/pfm_boost_ctrl.sv
module pfm_boost_ctrl
  import pfm_boost_pkg::*;
#(
  parameter int unsigned BLANK_CYC   = 4,
  parameter int unsigned OFF_CYC     = 50,
  parameter int unsigned MAX_ON_CYC  = 200,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cur_trip_i,
  input  logic ov_i,
  input  logic shdn_i,
  output logic sw_en_o
);

  logic [FLAG_W-1:0] flags_raw, flags_sync;
  logic cs_sync, ov_sync, sd_sync;
  logic blank_act, trip_evt, maxon_evt;

  always_comb begin
    flags_raw          = '0;
    flags_raw[FLAG_CS] = cur_trip_i;
    flags_raw[FLAG_OV] = ov_i;
    flags_raw[FLAG_SD] = shdn_i;
  end

  pfm_sync #(
    .W      (FLAG_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (flags_raw),
    .sync_o  (flags_sync)
  );

  assign cs_sync = flags_sync[FLAG_CS];
  assign ov_sync = flags_sync[FLAG_OV];
  assign sd_sync = flags_sync[FLAG_SD];

  pfm_seq #(
    .BLANK_CYC  (BLANK_CYC),
    .OFF_CYC    (OFF_CYC),
    .MAX_ON_CYC (MAX_ON_CYC)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_i    (cs_sync),
    .ov_i    (ov_sync),
    .sd_i    (sd_sync),
    .sw_o    (sw_en_o),
    .blank_o (blank_act),
    .trip_o  (trip_evt),
    .maxon_o (maxon_evt)
  );

endmodule

// File: rtl/pfm_boost_chk.sv
module pfm_boost_chk #(
  parameter int unsigned MAX_ON_CYC = 200
) (
  input logic clk,
  input logic rst_n,
  input logic sw_en_o,
  input logic cs_sync,
  input logic ov_sync,
  input logic sd_sync,
  input logic blank_act,
  input logic trip_evt,
  input logic maxon_evt
);

  int unsigned hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_run <= 0;
    else if (sw_en_o) hi_run <= hi_run + 1;
    else              hi_run <= 0;
  end

  p_reset_off_r1: assert property (@(posedge clk) !rst_n |-> !sw_en_o);

  p_blank_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blank_act && cs_sync && !ov_sync && !sd_sync |=> sw_en_o);

  p_trip_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trip_evt |=> !sw_en_o);

  p_maxon_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    maxon_evt |=> !sw_en_o);

  p_max_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run <= MAX_ON_CYC);

  p_rise_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_en_o) |-> $past(!ov_sync && !sd_sync));

  p_ov_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ov_sync |=> !sw_en_o);

  p_sd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sd_sync |=> !sw_en_o);

endmodule

bind pfm_boost_ctrl pfm_boost_chk #(
  .MAX_ON_CYC (MAX_ON_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sw_en_o   (sw_en_o),
  .cs_sync   (cs_sync),
  .ov_sync   (ov_sync),
  .sd_sync   (sd_sync),
  .blank_act (blank_act),
  .trip_evt  (trip_evt),
  .maxon_evt (maxon_evt)
);

// File: tb/tb_pfm_boost_ctrl.sv
module tb_pfm_boost_ctrl;

  localparam int BLANK = 4;
  localparam int OFFT  = 50;
  localparam int MAXON = 200;
  localparam int LAT   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, ov = 1'b0, sd = 1'b0;
  logic sw;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pfm_boost_ctrl #(
    .BLANK_CYC   (BLANK),
    .OFF_CYC     (OFFT),
    .MAX_ON_CYC  (MAXON),
    .SYNC_STAGES (2)
  ) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_trip_i (cs),
    .ov_i       (ov),
    .shdn_i     (sd),
    .sw_en_o    (sw)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Called at the first negedge sample with sw high (k = 0).
  // kind 0: one-cycle current pulse at k == t; 1: raise ov at k == t; 2: raise sd at k == t.
  task automatic measure_on(input int t, input int kind, output int w);
    int k;
    bit stop;
    w = 1; k = 0; stop = 1'b0;
    while (!stop) begin
      if (k == t) begin
        if (kind == 0) cs = 1'b1;
        else if (kind == 1) ov = 1'b1;
        else sd = 1'b1;
      end else if (k == t + 1 && kind == 0) begin
        cs = 1'b0;
      end
      @(negedge clk);
      k++;
      if (!sw) stop = 1'b1;
      else w++;
    end
    cs = 1'b0;
  endtask

  // Called at the first low sample; returns low width, ends on the rise sample.
  task automatic measure_off(output int w);
    w = 1;
    @(negedge clk);
    while (!sw) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic wait_rise(output int lat);
    lat = 0;
    while (!sw) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_low(input int n, input string req);
    int highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sw) highs++;
    end
    chk(highs == 0, req, "switch held off (high samples)", highs, 0);
  endtask

  task automatic t_reset_and_free_run;
    int w;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(sw == 1'b0, "R1", "switch during reset", int'(sw), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(sw == 1'b1, "R3", "turn-on one edge after reset release", int'(sw), 1);
    measure_on(-1, 0, w);
    chk(w == MAXON, "R6", "on width without trip", w, MAXON);
    measure_off(w);
    chk(w == OFFT, "R7", "off width after max on-time", w, OFFT);
  endtask

  task automatic t_trip_after_blank;
    int w;
    measure_on(10, 0, w);
    chk(w == 10 + LAT, "R5", "on width with trip at k=10", w, 10 + LAT);
    measure_off(w);
    chk(w == OFFT, "R5", "forced off-time after trip", w, OFFT);
    measure_on(BLANK - 2, 0, w);
    chk(w == BLANK + 1, "R4", "trip in first cycle after blanking", w, BLANK + 1);
    measure_off(w);
    chk(w == OFFT, "R5", "forced off-time after boundary trip", w, OFFT);
  endtask

  task automatic t_blank_ignore;
    int w;
    measure_on(BLANK - 3, 0, w);
    chk(w == MAXON, "R4", "current pulse inside blanking ignored", w, MAXON);
    measure_off(w);
    chk(w == OFFT, "R6", "off width after ignored pulse", w, OFFT);
  endtask

  task automatic t_ov_hold;
    int w, lat;
    measure_on(20, 1, w);
    chk(w == 20 + LAT, "R8", "over-voltage ends conduction", w, 20 + LAT);
    check_low(100, "R8");
    ov = 1'b0;
    wait_rise(lat);
    chk(lat == LAT, "R2", "latency from ov release to turn-on", lat, LAT);
    measure_on(-1, 0, w);
    chk(w == MAXON, "R6", "full on width after ov release", w, MAXON);
    measure_off(w);
    chk(w == OFFT, "R7", "off width, then turn-on", w, OFFT);
  endtask

  task automatic t_ov_after_off;
    int w, lat;
    measure_on(10, 0, w);
    chk(w == 10 + LAT, "R5", "trip before ov hold", w, 10 + LAT);
    ov = 1'b1;
    check_low(OFFT + 70, "R7");
    ov = 1'b0;
    wait_rise(lat);
    chk(lat == LAT, "R7", "turn-on once ov clears after off-time", lat, LAT);
  endtask

  task automatic t_shutdown;
    int w, lat;
    measure_on(0, 2, w);
    chk(w == LAT, "R9", "shutdown overrides blanking", w, LAT);
    check_low(80, "R9");
    sd = 1'b0;
    wait_rise(lat);
    chk(lat == LAT, "R9", "latency from shutdown release", lat, LAT);
  endtask

  task automatic t_reset_mid;
    int w;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(sw == 1'b0, "R1", "switch off at once on reset", int'(sw), 0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sw == 1'b1, "R3", "turn-on after mid-pulse reset", int'(sw), 1);
    measure_on(-1, 0, w);
    chk(w == MAXON, "R1", "timers cleared by reset", w, MAXON);
  endtask

  initial begin
    t_reset_and_free_run();
    t_trip_after_blank();
    t_blank_ignore();
    t_ov_hold();
    t_ov_after_off();
    t_shutdown();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule